// File: doc/BRIEF.md
# Hit-Channel Frame Serializer

This block empties the digitized results of a multi-channel front-end towards an external concentrator once a conversion run has finished. A sequencer pulses a start input together with a mask that marks which channels recorded a hit. The block then visits only the marked channels, lowest index first. For each one it builds a fixed-length word and shifts it out on one data line, with a strobe that is high for exactly the bits that belong to a frame. The word holds the channel tag, the coarse time stamp, the charge code and the fine time code.

A fixed quiet interval separates consecutive frames. During this interval the strobe and the data line stay low. After the last bit of the last frame, or at once when the mask is empty, the block raises a one-cycle completion pulse, so that the sequencer can release the analogue cells that were read. The per-channel time and charge values come in on wide flat buses. The sequencer keeps them stable from the start pulse until the completion pulse. With the default parameters a frame is 52 bits and the quiet interval is 10 serial clock cycles, which is 1 µs at a 10 MHz serial clock.

Top module: `hitsel_serializer`

## Requirements
- R1: After reset, the data line, the strobe, the busy flag and the completion pulse are all low.
- R2: Only channels whose hit-mask bit is set at the accepted start produce a frame, and frames leave in ascending channel index. The number of frames equals the number of set mask bits.
- R3: Each frame is FRAME_W = 52 consecutive strobed bits, sent most significant bit first. In transmission order the bits are the 4-bit channel index, the 24-bit coarse time, the 12-bit charge and the 12-bit fine time. The fields for channel c are taken from bit slices [c*W +: W] of the coarse, charge and fine buses.
- R4: Between two frames of one readout there are exactly GAP_CYC = 10 cycles with the strobe low.
- R5: The completion pulse lasts one cycle. With n > 0 hits it occurs in the cycle after the last strobed bit. With an empty mask it occurs in the second cycle after start is sampled, and no bit is strobed.
- R6: A start pulse that arrives while busy is high has no effect: the frames and the mask of the readout in progress are unchanged.
- R7: Busy rises in the cycle after start is sampled while idle, and that cycle carries no strobe. The first strobed bit follows one cycle later. Busy falls in the cycle after the completion pulse.
- R8: The data line is low in every cycle in which the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a readout (sampled only while idle) |
| hit_mask_i | input | NUM_CH | One bit per channel, 1 = hit |
| coarse_i | input | NUM_CH*CT_W | Coarse time stamps, channel c at [c*CT_W +: CT_W] |
| charge_i | input | NUM_CH*CHG_W | Charge codes, channel c at [c*CHG_W +: CHG_W] |
| fine_i | input | NUM_CH*FT_W | Fine time codes, channel c at [c*FT_W +: FT_W] |
| sdata_o | output | 1 | Serial frame data |
| sstrobe_o | output | 1 | High for each valid frame bit |
| busy_o | output | 1 | Readout in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: 16 channels, a 24-bit coarse field, 12-bit charge and fine fields, and a 10-cycle gap. This yields the full 52-bit frame and a 4-bit tag whose extreme values 0 and 15 both appear in directed cases. With this set the all-hit mask drives the longest readout of 16 frames and 15 gaps. Alternating masks and a single top channel exercise the scan order and its end-of-mask handling. Random masks and random field values cover field alignment at every bit position.

// File: rtl/hitsel_pkg.sv
package hitsel_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_SHIFT,
      ST_GAP,
      ST_DONE
   } rdo_state_e;
endpackage

// File: rtl/hitsel_pick.sv
// Lowest-index set bit of the pending mask, with its one-hot form.
module hitsel_pick #(
   parameter int NUM_CH = 16,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0] pend_i,
   output logic [CH_W-1:0]   idx_o,
   output logic [NUM_CH-1:0] onehot_o,
   output logic              any_o
);
   always_comb begin
      idx_o = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (pend_i[i]) idx_o = CH_W'(i);
      end
   end

   assign any_o    = |pend_i;
   assign onehot_o = any_o ? (NUM_CH'(1) << idx_o) : '0;
endmodule

// File: rtl/hitsel_frame_mux.sv
// Builds every channel's frame word and selects one by index.
module hitsel_frame_mux #(
   parameter int NUM_CH = 16,
   parameter int CT_W   = 24,
   parameter int CHG_W  = 12,
   parameter int FT_W   = 12,
   localparam int CH_W    = $clog2(NUM_CH),
   localparam int FRAME_W = CH_W + CT_W + CHG_W + FT_W
) (
   input  logic [CH_W-1:0]         idx_i,
   input  logic [NUM_CH*CT_W-1:0]  coarse_i,
   input  logic [NUM_CH*CHG_W-1:0] charge_i,
   input  logic [NUM_CH*FT_W-1:0]  fine_i,
   output logic [FRAME_W-1:0]      frame_o
);
   logic [FRAME_W-1:0] words [NUM_CH];

   for (genvar g = 0; g < NUM_CH; g++) begin : g_word
      localparam logic [CH_W-1:0] TAG = CH_W'(g);
      assign words[g] = {TAG,
                         coarse_i[g*CT_W +: CT_W],
                         charge_i[g*CHG_W +: CHG_W],
                         fine_i[g*FT_W +: FT_W]};
   end

   assign frame_o = words[idx_i];
endmodule

// File: rtl/hitsel_shifter.sv
// Parallel-load, MSB-first shift register.
module hitsel_shifter #(
   parameter int WIDTH = 52
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             shift_i,
   input  logic [WIDTH-1:0] data_i,
   output logic             msb_o
);
   logic [WIDTH-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sr_q <= '0;
      else if (load_i)  sr_q <= data_i;
      else if (shift_i) sr_q <= {sr_q[WIDTH-2:0], 1'b0};
   end

   assign msb_o = sr_q[WIDTH-1];
endmodule

// File: rtl/hitsel_gap.sv
// Counts the quiet cycles between frames.
module hitsel_gap #(
   parameter int GAP_CYC = 10,
   localparam int GW = $clog2(GAP_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic expire_o
);
   logic [GW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (!en_i) cnt_q <= '0;
      else            cnt_q <= cnt_q + GW'(1);
   end

   assign expire_o = en_i && (cnt_q == GW'(GAP_CYC - 1));
endmodule

// File: rtl/hitsel_serializer.sv
module hitsel_serializer
   import hitsel_pkg::*;
#(
   parameter int NUM_CH  = 16,
   parameter int CT_W    = 24,
   parameter int CHG_W   = 12,
   parameter int FT_W    = 12,
   parameter int GAP_CYC = 10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [NUM_CH-1:0]       hit_mask_i,
   input  logic [NUM_CH*CT_W-1:0]  coarse_i,
   input  logic [NUM_CH*CHG_W-1:0] charge_i,
   input  logic [NUM_CH*FT_W-1:0]  fine_i,
   output logic                    sdata_o,
   output logic                    sstrobe_o,
   output logic                    busy_o,
   output logic                    done_o
);
   localparam int CH_W    = $clog2(NUM_CH);
   localparam int FRAME_W = CH_W + CT_W + CHG_W + FT_W;
   localparam int BIT_W   = $clog2(FRAME_W);

   if (NUM_CH < 2) begin : g_bad_ch
      $error("NUM_CH must be at least 2");
   end
   if (GAP_CYC < 1) begin : g_bad_gap
      $error("GAP_CYC must be at least 1");
   end
   if (CT_W < 1 || CHG_W < 1 || FT_W < 1) begin : g_bad_w
      $error("field widths must be positive");
   end

   rdo_state_e         state_q;
   logic [NUM_CH-1:0]  pend_q;
   logic [BIT_W-1:0]   bit_q;
   logic [CH_W-1:0]    pick_idx;
   logic [NUM_CH-1:0]  pick_oh;
   logic               pick_any;
   logic [FRAME_W-1:0] frame;
   logic               gap_exp;
   logic               sr_load;
   logic               sr_msb;
   logic               last_bit;

   hitsel_pick #(.NUM_CH(NUM_CH)) pick_i (
      .pend_i   (pend_q),
      .idx_o    (pick_idx),
      .onehot_o (pick_oh),
      .any_o    (pick_any)
   );

   hitsel_frame_mux #(
      .NUM_CH(NUM_CH), .CT_W(CT_W), .CHG_W(CHG_W), .FT_W(FT_W)
   ) mux_i (
      .idx_i    (pick_idx),
      .coarse_i (coarse_i),
      .charge_i (charge_i),
      .fine_i   (fine_i),
      .frame_o  (frame)
   );

   hitsel_gap #(.GAP_CYC(GAP_CYC)) gap_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (state_q == ST_GAP),
      .expire_o (gap_exp)
   );

   assign sr_load  = ((state_q == ST_LOAD) && pick_any) || gap_exp;
   assign last_bit = (bit_q == BIT_W'(FRAME_W - 1));

   hitsel_shifter #(.WIDTH(FRAME_W)) sr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (sr_load),
      .shift_i (state_q == ST_SHIFT),
      .data_i  (frame),
      .msb_o   (sr_msb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= '0;
         bit_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  pend_q  <= hit_mask_i;
                  state_q <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               if (pick_any) begin
                  pend_q  <= pend_q & ~pick_oh;
                  bit_q   <= '0;
                  state_q <= ST_SHIFT;
               end else begin
                  state_q <= ST_DONE;
               end
            end
            ST_SHIFT: begin
               bit_q <= bit_q + BIT_W'(1);
               if (last_bit) state_q <= (pend_q != '0) ? ST_GAP : ST_DONE;
            end
            ST_GAP: begin
               if (gap_exp) begin
                  pend_q  <= pend_q & ~pick_oh;
                  bit_q   <= '0;
                  state_q <= ST_SHIFT;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sstrobe_o = (state_q == ST_SHIFT);
   assign sdata_o   = sstrobe_o & sr_msb;
   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = (state_q == ST_DONE);
endmodule

// File: rtl/hitsel_serializer_chk.sv
module hitsel_serializer_chk #(
   parameter int FRAME_W = 52,
   parameter int GAP_CYC = 10
) (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic sdata_o,
   input logic sstrobe_o,
   input logic busy_o,
   input logic done_o
);
   localparam int RW = $clog2(FRAME_W + GAP_CYC + 2);

   logic [RW-1:0] run_q;
   logic [RW-1:0] quiet_q;
   logic          seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= '0;
         quiet_q <= '0;
         seen_q  <= 1'b0;
      end else begin
         run_q <= sstrobe_o ? run_q + RW'(1) : '0;
         if (!busy_o) begin
            quiet_q <= '0;
            seen_q  <= 1'b0;
         end else if (sstrobe_o) begin
            quiet_q <= '0;
            seen_q  <= 1'b1;
         end else if (seen_q) begin
            quiet_q <= quiet_q + RW'(1);
         end
      end
   end

   AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !sstrobe_o |-> !sdata_o); // R8
   AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sstrobe_o) |-> (run_q == RW'(FRAME_W))); // R3
   AST_GAP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sstrobe_o) && seen_q) |-> (quiet_q == RW'(GAP_CYC))); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R5
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!sstrobe_o && busy_o)); // R5
   AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o); // R7
   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && !sstrobe_o)); // R7
   AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      sstrobe_o |-> busy_o); // R7
endmodule

bind hitsel_serializer hitsel_serializer_chk #(
   .FRAME_W (FRAME_W),
   .GAP_CYC (GAP_CYC)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .sdata_o   (sdata_o),
   .sstrobe_o (sstrobe_o),
   .busy_o    (busy_o),
   .done_o    (done_o)
);

// File: tb/hitsel_serializer_tb_top.sv
module hitsel_serializer_tb_top;
   localparam int NCH = 16;
   localparam int CTW = 24;
   localparam int QW  = 12;
   localparam int FTW = 12;
   localparam int GAP = 10;
   localparam int FW  = 4 + CTW + QW + FTW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [NCH-1:0] mask = '0;
   logic [NCH*CTW-1:0] coarse = '0;
   logic [NCH*QW-1:0]  charge = '0;
   logic [NCH*FTW-1:0] fine = '0;
   logic sdata, sstrobe, busy, done;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   hitsel_serializer dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .hit_mask_i (mask),
      .coarse_i   (coarse),
      .charge_i   (charge),
      .fine_i     (fine),
      .sdata_o    (sdata),
      .sstrobe_o  (sstrobe),
      .busy_o     (busy),
      .done_o     (done)
   );

   task automatic check(input string req, input bit ok, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [FW-1:0] exp_frame(input int c);
      return {4'(c), coarse[c*CTW +: CTW], charge[c*QW +: QW], fine[c*FTW +: FTW]};
   endfunction

   function automatic int exp_done_k(input int n);
      return (n == 0) ? 2 : 1 + n*FW + (n-1)*GAP + 1;
   endfunction

   task automatic run_case(input logic [NCH-1:0] m, input bit poke);
      logic [FW-1:0] got [NCH];
      logic [FW-1:0] cur;
      int nfr, bitc, gap, gap_bad, quiet_bad, done_k, done_cnt, first_k, nexp, fi;
      bit seen, ended;
      for (int c = 0; c < NCH; c++) begin
         coarse[c*CTW +: CTW] = CTW'($urandom);
         charge[c*QW +: QW]   = QW'($urandom);
         fine[c*FTW +: FTW]   = FTW'($urandom);
      end
      nfr = 0; bitc = 0; gap = 0; gap_bad = 0; quiet_bad = 0;
      done_k = -1; done_cnt = 0; first_k = -1; seen = 0; ended = 0; cur = '0;
      @(negedge clk);
      mask = m; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 1; k < 3000; k++) begin
         if (k == 1)
            check("R7 busy rises without strobe", busy && !sstrobe, {busy, sstrobe}, 2'b10);
         if (poke && k == 6) begin mask = ~m; start = 1'b1; end
         if (poke && k == 7) begin mask = m;  start = 1'b0; end
         if (sstrobe) begin
            if (first_k < 0) first_k = k;
            if (seen && bitc == 0 && gap != GAP) gap_bad++;
            cur = {cur[FW-2:0], sdata};
            bitc++;
            if (bitc == FW) begin
               if (nfr < NCH) got[nfr] = cur;
               nfr++; bitc = 0; seen = 1; gap = 0;
            end
         end else begin
            if (sdata) quiet_bad++;
            if (seen && busy && !done) gap++;
         end
         if (done) begin
            done_cnt++;
            if (done_k < 0) done_k = k;
         end
         if (done_k >= 0 && k == done_k + 1) begin
            check("R7 busy falls after done", !busy && !done, {busy, done}, 2'b00);
            ended = 1;
            break;
         end
         @(negedge clk);
      end
      check("R5 readout completes", ended, ended, 1);
      nexp = $countones(m);
      check("R2 frame count", nfr == nexp, nfr, nexp);
      fi = 0;
      for (int c = 0; c < NCH; c++) begin
         if (m[c] && fi < nfr && fi < NCH) begin
            check("R3 frame content and R2 order", got[fi] == exp_frame(c), got[fi], exp_frame(c));
            fi++;
         end
      end
      check("R3 no partial frame", bitc == 0, bitc, 0);
      if (nexp > 1) check("R4 gap length", gap_bad == 0, gap_bad, 0);
      check("R8 data quiet without strobe", quiet_bad == 0, quiet_bad, 0);
      check("R5 single done pulse", done_cnt == 1, done_cnt, 1);
      check("R5 done timing", done_k == exp_done_k(nexp), done_k, exp_done_k(nexp));
      if (nexp > 0) check("R7 first strobe latency", first_k == 2, first_k, 2);
      else          check("R5 empty mask sends nothing", first_k < 0, first_k, -1);
      if (poke) check("R6 start while busy ignored", nfr == nexp, nfr, nexp);
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      check("R1 reset sdata", sdata == 1'b0, sdata, 0);
      check("R1 reset strobe", sstrobe == 1'b0, sstrobe, 0);
      check("R1 reset busy", busy == 1'b0, busy, 0);
      check("R1 reset done", done == 1'b0, done, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_case(16'h0000, 0);
      run_case(16'h0001, 0);
      run_case(16'h8000, 0);
      run_case(16'hFFFF, 0);
      run_case(16'hAAAA, 0);
      run_case(16'h5555, 1);
      run_case(16'h8001, 1);
      for (int i = 0; i < 8; i++) run_case(16'($urandom), (i % 2) == 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule